// File: doc/BRIEF.md
# Programmable Trigger Pulse Generator

This block drives one trigger line in response to a one-cycle command strobe. Each accepted command either emits a single high pulse of programmable length or inverts the present level of the line. The choice depends on a mode select. Pulse lengths are measured in ticks of an internal time base. The time base divides the input clock by a programmable factor from 1 to 32.

The divider, width and mode settings are copied into internal holding registers on every cycle in which the busy flag is low. While the busy flag is high, the holding registers keep their values, so the settings cannot shift under a running command stream. A done strobe marks the end of every pulse and every toggle. The enable input forces the whole unit to a quiet state with the line low.

Top module: `trig_pulse_gen`

## Requirements
- R1: The time base ticks once every div_i+1 clock cycles. The 5-bit divider field covers divide-by-1 (value 0) to divide-by-32 (value 31). The time base restarts from zero when a pulse begins.
- R2: In pulse mode (tgl_i = 0), an accepted command raises trig_o in the next cycle. trig_o stays high for exactly (pw_i+1)*(div_i+1) clock cycles, so the 4-bit width field gives 1 to 16 ticks.
- R3: done_o is high for one cycle, in the first cycle in which trig_o is low again after a pulse, and at no other time during the pulse.
- R4: In toggle mode (tgl_i = 1), an accepted command inverts trig_o in the next cycle and raises done_o for that one cycle. No timed pulse is produced.
- R5: div_i, pw_i and tgl_i are captured in every cycle in which busy_i is low. While busy_i is high, changes on these inputs are ignored and the last captured values remain in force.
- R6: While en is low, trig_o and done_o are 0 from the next cycle on, the toggle level is cleared, and commands are ignored.
- R7: A command that arrives while a pulse is active is ignored, including one in the last cycle of the pulse. The pulse length is unchanged, and no second pulse follows.
- R8: After reset, trig_o and done_o are 0. The prescaler count, width count and toggle level are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enable |
| div_i | input | 5 | Time-base divider, divide by value+1 |
| pw_i | input | 4 | Pulse width in ticks, value+1 |
| tgl_i | input | 1 | 1 = toggle mode, 0 = pulse mode |
| busy_i | input | 1 | Executing flag; freezes the captured settings |
| cmd_i | input | 1 | One-cycle trigger command strobe |
| trig_o | output | 1 | Trigger line |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Two events can fall in the same cycle: the end of a pulse (the final tick with the width count at its limit) and the arrival of a new command. The bench provokes this by holding cmd_i high in the last high cycle of a pulse, and also in a middle cycle of the same pulse. It judges the result by the pulse length, by done_o rising exactly once as trig_o falls, and by trig_o staying low in the following cycles. A second collision, a disable arriving mid-pulse, is judged by trig_o and done_o both being low in the next cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned DIV_W_DEF = 5;
  localparam int unsigned PW_W_DEF  = 4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_START  = 2'd1,
    ACT_TOGGLE = 2'd2
  } trig_act_e;
endpackage

// File: rtl/trig_cfg_hold.sv
module trig_cfg_hold #(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned PW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic             tgl_i,
  output logic [DIV_W-1:0] div_q,
  output logic [PW_W-1:0]  pw_q,
  output logic             tgl_q
);
  logic [DIV_W-1:0] div_d;
  logic [PW_W-1:0]  pw_d;
  logic             tgl_d;
  logic             load;

  always_comb begin
    load  = ~busy_i;
    div_d = load ? div_i : div_q;
    pw_d  = load ? pw_i  : pw_q;
    tgl_d = load ? tgl_i : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pw_q  <= '0;
      tgl_q <= 1'b0;
    end else begin
      div_q <= div_d;
      pw_q  <= pw_d;
      tgl_q <= tgl_d;
    end
  end

  // R5: settings frozen while executing
  a_r5_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(div_q) && $stable(pw_q) && $stable(tgl_q)));
endmodule

// File: rtl/trig_prescale.sv
module trig_prescale #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == lim);
    tick = run & wrap;
    if (!run || wrap) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: time base restarts from zero whenever idle
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/trig_pulse_unit.sv
module trig_pulse_unit
  import trig_pkg::*;
#(
  parameter int unsigned PW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cmd_i,
  input  logic            tgl_mode,
  input  logic [PW_W-1:0] pw_lim,
  input  logic            tick,
  output logic            active_q,
  output logic            trig_q,
  output logic            done_q
);
  logic [PW_W-1:0] wcnt_q, wcnt_d;
  logic            active_d, trig_d, done_d;
  logic            last;
  trig_act_e       act;

  always_comb begin
    if (en && cmd_i && !active_q) act = tgl_mode ? ACT_TOGGLE : ACT_START;
    else                          act = ACT_NONE;
    last = active_q & tick & (wcnt_q == pw_lim);
  end

  always_comb begin
    active_d = active_q;
    wcnt_d   = wcnt_q;
    trig_d   = trig_q;
    done_d   = 1'b0;
    if (!en) begin
      active_d = 1'b0;
      wcnt_d   = '0;
      trig_d   = 1'b0;
    end else begin
      unique case (act)
        ACT_START: begin
          active_d = 1'b1;
          wcnt_d   = '0;
          trig_d   = 1'b1;
        end
        ACT_TOGGLE: begin
          trig_d = ~trig_q;
          done_d = 1'b1;
        end
        default: begin
          if (last) begin
            active_d = 1'b0;
            wcnt_d   = '0;
            trig_d   = 1'b0;
            done_d   = 1'b1;
          end else if (active_q && tick) begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wcnt_q   <= '0;
      trig_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      wcnt_q   <= wcnt_d;
      trig_q   <= trig_d;
      done_q   <= done_d;
    end
  end

  // R6: disable forces quiet outputs
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!trig_q && !done_q));
  // R7: an active pulse continues until its final tick, commands or not
  a_r7_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active_q && !(tick && (wcnt_q == pw_lim))) |=> (active_q && trig_q));
  // R3: a pulse that ends with enable present reports done
  a_r3_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active_q) && $past(en)) |-> (done_q && !trig_q));
  // R4: a toggle command never starts a timed pulse
  a_r4_toggle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd_i && !active_q && tgl_mode) |=> (!active_q && done_q));
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
  import trig_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF,
  parameter int unsigned PW_W  = PW_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic             tgl_i,
  input  logic             busy_i,
  input  logic             cmd_i,
  output logic             trig_o,
  output logic             done_o
);
  localparam int unsigned SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic [DIV_W-1:0]  div_q;
  logic [PW_W-1:0]   pw_q;
  logic              tgl_q;
  logic              tick;
  logic              active;
  logic              run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  trig_cfg_hold #(.DIV_W(DIV_W), .PW_W(PW_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .busy_i (busy_i),
    .div_i  (div_i),
    .pw_i   (pw_i),
    .tgl_i  (tgl_i),
    .div_q  (div_q),
    .pw_q   (pw_q),
    .tgl_q  (tgl_q)
  );

  assign run = active & en;

  trig_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .lim   (div_q),
    .tick  (tick)
  );

  trig_pulse_unit #(.PW_W(PW_W)) u_pls (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (en),
    .cmd_i    (cmd_i),
    .tgl_mode (tgl_q),
    .pw_lim   (pw_q),
    .tick     (tick),
    .active_q (active),
    .trig_q   (trig_o),
    .done_q   (done_o)
  );

  // R8: quiet outputs while held in reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!trig_o && !done_o));
endmodule

// File: tb/trig_pulse_gen_tb.sv
`timescale 1ns/1ps
module trig_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] div_i;
  logic [3:0] pw_i;
  logic       tgl_i;
  logic       busy_i;
  logic       cmd_i;
  logic       trig_o;
  logic       done_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  trig_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_i(div_i), .pw_i(pw_i),
    .tgl_i(tgl_i), .busy_i(busy_i), .cmd_i(cmd_i),
    .trig_o(trig_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk); cmd_i = 1'b1;
    @(negedge clk); cmd_i = 1'b0;
  endtask

  // count high cycles of a pulse whose first high cycle is now
  task automatic measure(string req, int exp_w);
    int n = 0;
    while (trig_o && n < 1000) begin
      if (done_o) chk("R3 done during pulse", 1, 0);
      n++;
      @(negedge clk);
    end
    chk(req, n, exp_w);
    chk("R3 done at fall", done_o, 1);
    @(negedge clk);
    chk("R3 done one cycle", done_o, 0);
  endtask

  task automatic run_pulse(int dv, int pw);
    @(negedge clk); div_i = dv[4:0]; pw_i = pw[3:0]; tgl_i = 1'b0; busy_i = 1'b0;
    fire();
    measure("R1 R2 width", (pw + 1) * (dv + 1));
  endtask

  initial begin
    #1_600_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL R8 watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; div_i = '0; pw_i = '0; tgl_i = 1'b0;
    busy_i = 1'b0; cmd_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset trig", trig_o, 0);
    chk("R8 reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after release trig", trig_o, 0);
    en = 1'b1;

    // R1 R2 R3: full sweep of divider and width
    for (int d = 0; d < 32; d++)
      for (int w = 0; w < 16; w++)
        run_pulse(d, w);

    // R7: commands mid-pulse and in the final cycle of a 6-cycle pulse
    @(negedge clk); div_i = 5'd1; pw_i = 4'd2; tgl_i = 1'b0;
    fire();
    for (int k = 1; k <= 6; k++) begin
      chk("R7 pulse high", trig_o, 1);
      cmd_i = (k == 3 || k == 6);
      @(negedge clk);
    end
    cmd_i = 1'b0;
    chk("R7 fall after collision", trig_o, 0);
    chk("R7 done at collision end", done_o, 1);
    repeat (2) begin
      @(negedge clk);
      chk("R7 no second pulse", trig_o, 0);
    end

    // R4: toggle mode
    @(negedge clk); tgl_i = 1'b1;
    fire();
    chk("R4 toggle high", trig_o, 1);
    chk("R4 toggle done", done_o, 1);
    @(negedge clk);
    chk("R4 level held", trig_o, 1);
    chk("R4 done one cycle", done_o, 0);
    repeat (5) @(negedge clk);
    chk("R4 no timed fall", trig_o, 1);
    fire();
    chk("R4 toggle low", trig_o, 0);
    chk("R4 second done", done_o, 1);

    // R5: lock while busy; pulse must use captured div 0, width 0, pulse mode
    @(negedge clk); div_i = 5'd0; pw_i = 4'd0; tgl_i = 1'b0; busy_i = 1'b0;
    @(negedge clk); busy_i = 1'b1; div_i = 5'd3; pw_i = 4'd3; tgl_i = 1'b1;
    @(negedge clk);
    fire();
    measure("R5 locked width", 1);
    fire();
    measure("R5 locked mode", 1);
    @(negedge clk); busy_i = 1'b0;
    @(negedge clk); tgl_i = 1'b0;
    fire();
    measure("R5 released width", 16);

    // R6: disable mid-pulse
    @(negedge clk); div_i = 5'd3; pw_i = 4'd3;
    fire();
    repeat (4) @(negedge clk);
    chk("R6 pulse running", trig_o, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R6 trig cleared", trig_o, 0);
    chk("R6 no done", done_o, 0);
    // R6: disable clears toggle level, commands ignored
    en = 1'b1; tgl_i = 1'b1;
    @(negedge clk);
    fire();
    chk("R6 toggled high", trig_o, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R6 toggle level cleared", trig_o, 0);
    fire();
    chk("R6 cmd ignored trig", trig_o, 0);
    chk("R6 cmd ignored done", done_o, 0);
    en = 1'b1;
    fire();
    chk("R6 level restarts from zero", trig_o, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule